// File: doc/BRIEF.md
# Branch Bias Promotion Table

This block holds one small record per conditional branch and uses it to decide when a branch is steady enough to be treated as statically predicted. Each record holds a saturating counter that measures how often a branch repeats the direction it took last time. Retired conditional branches arrive on an update stream, each carrying the branch's word address and its resolved direction. The trace fill logic looks up a branch by word address and gets back two answers: whether the branch is promoted, and the fixed direction to use when it is.

A branch is promoted once its counter rises above a programmable threshold. It loses that status in two ways. The first is two contradictions of its fixed direction in a row, which also wipes the record. The second is its counter falling below the threshold. A single contradiction, such as a loop exit, does not demote a branch by itself.

The update stream uses valid/ready. The table accepts one update every cycle, so `upd_ready` is held high and no back-pressure is ever applied. A beat is consumed on any rising clock edge where `upd_valid` is high. The lookup port is plain combinational control.

Top module: `bias_promo_table`

## Requirements
- R1: On an update whose slot is empty or holds a different tag, the slot is rewritten with count 0, not promoted, and the update's direction saved as the previous direction. After reset, and for any address whose slot holds another tag, the lookup returns hit 0, promote 0 and direction 0.
- R2: On an update that hits, the count rises by one when the direction equals the saved previous direction and falls by one otherwise. The count saturates at 15 and at 0. The new direction then becomes the previous direction.
- R3: A branch that is not promoted becomes promoted when its count after the update is strictly greater than `cfg_thresh`. Its fixed direction is the direction of that update (1 = taken).
- R4: The lookup is combinational and reflects the table as it stands. An update accepted at a clock edge is visible at the lookup only after that edge.
- R5: If a promoted branch receives two updates in a row that contradict its fixed direction, it is demoted and its count is cleared to 0.
- R6: A single contradiction followed by an update that agrees with the fixed direction resets the contradiction tracker. After that, two further consecutive contradictions are needed for R5.
- R7: A promoted branch whose count after an update is strictly below `cfg_thresh` is demoted.
- R8: The slot index is `upd_addr[5:0]` and the tag is `upd_addr[29:6]` (the same split applies to `qry_addr`). The table is direct-mapped with 64 slots, so two addresses that share an index evict each other.
- R9: `upd_ready` is 1 at all times after reset, and every beat with `upd_valid` high is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties the table |
| cfg_thresh | input | 4 | Promotion threshold |
| upd_valid | input | 1 | Retired branch beat is valid |
| upd_ready | output | 1 | Always 1: the table accepts a beat every cycle |
| upd_addr | input | 30 | Word address of the retired branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| qry_addr | input | 30 | Word address looked up by the fill logic |
| qry_hit | output | 1 | A valid slot matches the tag |
| qry_promote | output | 1 | Branch is promoted |
| qry_taken | output | 1 | Fixed direction of a promoted branch, 0 otherwise |

## Verification
The table is driven with runs of identical outcomes. These show where promotion happens relative to the threshold and that the count saturates at 15, including the case of threshold 15, which can never promote. Interleaved patterns separate the two ways of losing promotion. A contradiction followed by an agreeing outcome must not clear the record. Two contradictions in a row must clear it. A contradiction that drags the count below the threshold demotes the branch without clearing it. A pseudo-random stream over a few addresses that collide on two slots, with the threshold swept from 0 to 5, is compared against an arithmetic model after every beat. This stream exercises eviction and the same-cycle lookup versus next-cycle lookup ordering.

// File: rtl/bias_pkg.sv
package bias_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             prev;
    logic             prom;
    logic             dir;
    logic             miss;
  } bias_state_t;
endpackage

// File: rtl/bias_lookup.sv
module bias_lookup #(
  parameter int TAG_W = 24
) (
  input  logic             vld_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] tag_req_i,
  output logic             hit_o
);
  assign hit_o = vld_i && (tag_i == tag_req_i);
endmodule

// File: rtl/bias_update.sv
module bias_update
  import bias_pkg::*;
(
  input  logic             hit_i,
  input  bias_state_t      st_i,
  input  logic             taken_i,
  input  logic [CNT_W-1:0] thr_i,
  output bias_state_t      st_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             same;
  logic [CNT_W-1:0] c_nxt;

  always_comb begin
    same  = (taken_i == st_i.prev);
    if (same) c_nxt = (st_i.cnt == CMAX) ? CMAX : st_i.cnt + 1'b1;
    else      c_nxt = (st_i.cnt == '0) ? '0 : st_i.cnt - 1'b1;
  end

  always_comb begin
    st_o = st_i;
    if (!hit_i) begin
      st_o.cnt  = '0;
      st_o.prev = taken_i;
      st_o.prom = 1'b0;
      st_o.dir  = 1'b0;
      st_o.miss = 1'b0;
    end else begin
      st_o.prev = taken_i;
      st_o.cnt  = c_nxt;
      if (st_i.prom) begin
        if (taken_i != st_i.dir) begin
          if (st_i.miss) begin
            st_o.cnt  = '0;
            st_o.prom = 1'b0;
            st_o.dir  = 1'b0;
            st_o.miss = 1'b0;
          end else begin
            st_o.miss = 1'b1;
            if (c_nxt < thr_i) begin
              st_o.prom = 1'b0;
              st_o.miss = 1'b0;
            end
          end
        end else begin
          st_o.miss = 1'b0;
          if (c_nxt < thr_i) st_o.prom = 1'b0;
        end
      end else if (c_nxt > thr_i) begin
        st_o.prom = 1'b1;
        st_o.dir  = taken_i;
        st_o.miss = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bias_promo_table.sv
module bias_promo_table
  import bias_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_hit,
  output logic              qry_promote,
  output logic              qry_taken
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tagq [DEPTH];
  bias_state_t      st   [DEPTH];

  logic [IDX_W-1:0] u_idx, q_idx;
  logic [TAG_W-1:0] u_tag, q_tag;
  logic             u_hit, fire;
  bias_state_t      st_u, st_nxt;

  assign u_idx = upd_addr[IDX_W-1:0];
  assign u_tag = upd_addr[ADDR_W-1:IDX_W];
  assign q_idx = qry_addr[IDX_W-1:0];
  assign q_tag = qry_addr[ADDR_W-1:IDX_W];
  assign st_u  = st[u_idx];

  assign upd_ready = 1'b1;
  assign fire      = upd_valid && upd_ready;

  bias_lookup #(.TAG_W(TAG_W)) u_qlk (
    .vld_i(vld[q_idx]), .tag_i(tagq[q_idx]), .tag_req_i(q_tag), .hit_o(qry_hit)
  );

  bias_lookup #(.TAG_W(TAG_W)) u_ulk (
    .vld_i(vld[u_idx]), .tag_i(tagq[u_idx]), .tag_req_i(u_tag), .hit_o(u_hit)
  );

  bias_update u_nxt (
    .hit_i(u_hit), .st_i(st_u), .taken_i(upd_taken), .thr_i(cfg_thresh), .st_o(st_nxt)
  );

  assign qry_promote = qry_hit && st[q_idx].prom;
  assign qry_taken   = qry_promote && st[q_idx].dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tagq[i] <= '0;
        st[i]   <= '0;
      end
    end else if (fire) begin
      vld[u_idx]  <= 1'b1;
      tagq[u_idx] <= u_tag;
      st[u_idx]   <= st_nxt;
    end
  end

  // Fresh slot after a tag miss.
  assert_alloc_fresh_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !u_hit) |=> (st[$past(u_idx)].cnt == '0 && !st[$past(u_idx)].prom
                          && st[$past(u_idx)].prev == $past(upd_taken)));

  assert_count_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && u_hit && st_u.cnt == CMAX && upd_taken == st_u.prev)
      |=> (st[$past(u_idx)].cnt == CMAX));

  assert_promote_gt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && u_hit && !st_u.prom)
      |=> (!st[$past(u_idx)].prom || st[$past(u_idx)].cnt > $past(cfg_thresh)));

  assert_double_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && u_hit && st_u.prom && st_u.miss && upd_taken != st_u.dir)
      |=> (!st[$past(u_idx)].prom && st[$past(u_idx)].cnt == '0));

  assert_low_demote_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && u_hit && st_u.prom)
      |=> (!st[$past(u_idx)].prom || st[$past(u_idx)].cnt >= $past(cfg_thresh)));

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n) upd_ready);
endmodule

// File: tb/tb_bias_promo_table.sv
`timescale 1ns/1ps
module tb_bias_promo_table;
  localparam int AW = 30;
  localparam int IW = 6;
  localparam int D  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    cfg_thresh = 4'd3;
  logic          upd_valid = 1'b0;
  logic          upd_ready;
  logic [AW-1:0] upd_addr = '0;
  logic          upd_taken = 1'b0;
  logic [AW-1:0] qry_addr = '0;
  logic          qry_hit, qry_promote, qry_taken;

  always #2.5 clk = ~clk;

  bias_promo_table dut (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_addr(upd_addr),
    .upd_taken(upd_taken), .qry_addr(qry_addr), .qry_hit(qry_hit),
    .qry_promote(qry_promote), .qry_taken(qry_taken)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model
  bit       m_v    [D];
  int       m_tag  [D];
  int       m_cnt  [D];
  bit       m_prev [D];
  bit       m_prom [D];
  bit       m_dir  [D];
  bit       m_miss [D];

  function automatic void model_upd(input logic [AW-1:0] a, input bit t);
    int i, tg, c;
    i  = int'(a[IW-1:0]);
    tg = int'(a[AW-1:IW]);
    if (!m_v[i] || m_tag[i] != tg) begin
      m_v[i] = 1; m_tag[i] = tg; m_cnt[i] = 0; m_prev[i] = t;
      m_prom[i] = 0; m_dir[i] = 0; m_miss[i] = 0;
    end else begin
      c = (t == m_prev[i]) ? ((m_cnt[i] == 15) ? 15 : m_cnt[i] + 1)
                           : ((m_cnt[i] == 0) ? 0 : m_cnt[i] - 1);
      m_prev[i] = t;
      m_cnt[i] = c;
      if (m_prom[i]) begin
        if (t != m_dir[i]) begin
          if (m_miss[i]) begin
            m_cnt[i] = 0; m_prom[i] = 0; m_dir[i] = 0; m_miss[i] = 0;
          end else begin
            m_miss[i] = 1;
            if (c < int'(cfg_thresh)) begin m_prom[i] = 0; m_miss[i] = 0; end
          end
        end else begin
          m_miss[i] = 0;
          if (c < int'(cfg_thresh)) m_prom[i] = 0;
        end
      end else if (c > int'(cfg_thresh)) begin
        m_prom[i] = 1; m_dir[i] = t; m_miss[i] = 0;
      end
    end
  endfunction

  function automatic logic [2:0] model_q(input logic [AW-1:0] a);
    int i;
    bit h, p;
    i = int'(a[IW-1:0]);
    h = m_v[i] && (m_tag[i] == int'(a[AW-1:IW]));
    p = h && m_prom[i];
    return {h, p, p && m_dir[i]};
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hit,promote,taken} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic qchk(input string req, input logic [AW-1:0] a);
    qry_addr = a;
    #1;
    chk(req, {qry_hit, qry_promote, qry_taken}, model_q(a));
  endtask

  // one update beat; checks the lookup before the edge (old state) and after
  task automatic upd(input string req, input logic [AW-1:0] a, input bit t);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_taken = t;
    qchk("R4 same-cycle", a);
    @(negedge clk);
    upd_valid = 1'b0;
    model_upd(a, t);
    qchk(req, a);
  endtask

  task automatic rdy_chk();
    n_chk++;
    if (upd_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R9: upd_ready actual=%b expected=1", upd_ready);
    end
  endtask

  localparam logic [AW-1:0] PA = 30'h0000_0045; // idx 5, tag 1
  localparam logic [AW-1:0] PB = 30'h0000_0089; // idx 9, tag 2
  localparam logic [AW-1:0] PC = 30'h0000_00C5; // idx 5, tag 3
  localparam logic [AW-1:0] PD = 30'h0000_010C; // idx 12, tag 4

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < D; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_cnt[i] = 0; m_prev[i] = 0;
      m_prom[i] = 0; m_dir[i] = 0; m_miss[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    qchk("R1 reset", PA);
    qchk("R1 reset", PB);
    rdy_chk();

    // R3: threshold 3, promotion exactly when count reaches 4
    cfg_thresh = 4'd3;
    upd("R1 alloc", PA, 1'b1);
    upd("R3 cnt1", PA, 1'b1);
    upd("R3 cnt2", PA, 1'b1);
    upd("R3 cnt3 not above", PA, 1'b1);
    upd("R3 cnt4 promote", PA, 1'b1);
    rdy_chk();

    // R6 then R5: saturate, single contradiction, agree, then two in a row
    for (int k = 0; k < 14; k++) upd("R2 climb", PA, 1'b1);
    upd("R6 first contradiction", PA, 1'b0);
    upd("R6 agree resets", PA, 1'b1);
    upd("R6 one more contradiction", PA, 1'b0);
    upd("R5 second consecutive", PA, 1'b0);
    upd("R2 floor after clear", PA, 1'b1);

    // R7: fall below threshold with a single contradiction
    upd("R1 alloc", PB, 1'b0);
    for (int k = 0; k < 4; k++) upd("R3 not-taken promote", PB, 1'b0);
    upd("R7 contradiction at threshold", PB, 1'b1);
    upd("R7 below threshold", PB, 1'b0);

    // R8: eviction by a colliding tag
    upd("R8 evict", PC, 1'b1);
    qchk("R8 old tag gone", PA);
    qchk("R8 other slot kept", PB);

    // R2: saturation makes threshold 15 unreachable, 14 reachable
    cfg_thresh = 4'd15;
    upd("R1 alloc", PD, 1'b1);
    for (int k = 0; k < 20; k++) upd("R2 saturate thr15", PD, 1'b1);
    cfg_thresh = 4'd14;
    upd("R3 saturated above 14", PD, 1'b1);

    // sweep: colliding addresses, thresholds 0..5
    lfsr = 16'hACE1;
    for (int th = 0; th < 6; th++) begin
      cfg_thresh = 4'(th);
      for (int k = 0; k < 300; k++) begin
        logic [AW-1:0] a;
        bit t;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        a = AW'((int'(lfsr[1:0]) % 3 + 1) * 64 + int'(lfsr[2]) + 20);
        t = (lfsr[7:5] != 3'b000) ^ lfsr[2];
        upd("R2/R3/R5/R7 sweep", a, t);
      end
      rdy_chk();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule